// File: doc/BRIEF.md
# Binary64 to 32-bit Integer Converter

This block turns a binary64 floating-point operand into a 32-bit integer. The integer can be signed or unsigned. A 3-bit code selects one of the five IEEE rounding modes. The 32-bit integer is always sign-extended into a 64-bit result word, the way a 64-bit register file expects a word-sized value, and this holds for unsigned conversions too. Two status flags go with each result: invalid and inexact. The other IEEE exception flags cannot arise from this operation, so the block has no outputs for them.

The datapath is combinational from the operand to a single output register. A valid/ready handshake sits on each side. The rounding increment is applied before the range check. Because of this, a value that rounds across a limit is caught, and the limits themselves are exact: -2^31 is a legal signed result, and 2^32 is not a legal unsigned one. Any value outside the range, and any NaN or infinity, is replaced by a fixed saturation value and raises the invalid flag.

Top module: `fcvt_f64_i32`

## Requirements
- R1: An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on `out_valid` and the output pins one cycle later. While `out_valid` is high and `out_ready` is low, the result stays stable and `in_ready` is low.
- R2: The rounding codes are 0 = nearest-even, 1 = toward zero, 2 = toward minus infinity, 3 = toward plus infinity and 4 = nearest with ties away from zero. Codes 5 to 7 behave as nearest-even.
- R3: When `in_signed` is 1, an operand that rounds to exactly -2^31 gives 0xFFFFFFFF80000000 with no flag set. A value that rounds to 2^31 or above, or to below -2^31, is out of range.
- R4: When `in_signed` is 0, an in-range result from 2^31 to 2^32-1 is sign-extended. For example, a value just below 2^31 rounded toward plus infinity gives 0xFFFFFFFF80000000.
- R5: When `in_signed` is 0, a value that rounds up to 2^32 saturates to 0xFFFFFFFFFFFFFFFF and sets invalid. It never wraps to zero.
- R6: An out-of-range result sets invalid and saturates to one of these values:
  - signed, too high: 0x000000007FFFFFFF
  - signed, too low: 0xFFFFFFFF80000000
  - unsigned, too high: 0xFFFFFFFFFFFFFFFF
  - unsigned, negative after rounding: 0
- R7: A NaN of either sign sets invalid. It returns 0x000000007FFFFFFF for signed and 0xFFFFFFFFFFFFFFFF for unsigned.
- R8: +infinity saturates high and -infinity saturates low, using the R6 values, and both set invalid.
- R9: In an unsigned conversion, a negative operand that rounds to zero (including -0.0) returns 0 with invalid clear. Inexact is set if the operand was not zero.
- R10: Inexact is set exactly when an in-range result differs from the operand. Invalid and inexact are never high together.
- R11: While reset is held and directly after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be accepted |
| in_operand | input | 64 | binary64 operand |
| in_signed | input | 1 | 1 = signed target, 0 = unsigned target |
| in_rm | input | 3 | Rounding mode code (R2) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be taken |
| out_result | output | 64 | Sign-extended 32-bit integer |
| out_nv | output | 1 | Invalid-operation flag |
| out_nx | output | 1 | Inexact flag |

## Verification
The result, invalid flag and inexact flag for an accepted operand are all due on the first clock edge after the accepting edge, because there is exactly one register on the path. The bench drives each operand on a falling edge and releases it on the next falling edge. Half a cycle after the registering edge it compares all three outputs against the expected values in its table. For the back-pressure case it holds `out_ready` low for several cycles and samples at each falling edge, to confirm that the first result stays put and that a second operand waiting at the input is taken only on the edge after `out_ready` rises.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  localparam int unsigned FP_EXP_W = 11;
  localparam int unsigned FP_MAN_W = 52;
  localparam int unsigned TGT_W    = 32;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_DOWN      = 3'd2,
    RM_UP        = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } rmode_e;

  // Decide whether the truncated magnitude gets +1.
  // rbit is the first dropped bit; sbit is the OR of all lower dropped bits.
  function automatic logic round_up(input logic [2:0] rm, input logic neg,
                                    input logic lsb, input logic rbit,
                                    input logic sbit);
    logic inc;
    case (rm)
      RM_ZERO:      inc = 1'b0;
      RM_DOWN:      inc = neg & (rbit | sbit);
      RM_UP:        inc = ~neg & (rbit | sbit);
      RM_NEAR_AWAY: inc = rbit;
      default:      inc = rbit & (sbit | lsb);
    endcase
    return inc;
  endfunction

endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify #(
  parameter int unsigned EXP_W = fcvt_pkg::FP_EXP_W,
  parameter int unsigned MAN_W = fcvt_pkg::FP_MAN_W,
  localparam int unsigned OP_W = EXP_W + MAN_W + 1
) (
  input  logic [OP_W-1:0]          op,
  output logic                     sign,
  output logic                     is_nan,
  output logic                     is_inf,
  output logic                     hidden,
  output logic [MAN_W-1:0]         frac,
  output logic signed [EXP_W+1:0]  uexp
);
  localparam int unsigned BIAS = (2 ** (EXP_W - 1)) - 1;

  logic [EXP_W-1:0] exp_f;
  logic             exp_max;

  assign sign    = op[OP_W-1];
  assign exp_f   = op[OP_W-2:MAN_W];
  assign frac    = op[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign is_nan  = exp_max & (|frac);
  assign is_inf  = exp_max & ~(|frac);
  // Zero and subnormals have no leading one.
  assign hidden  = |exp_f;
  assign uexp    = $signed({2'b00, exp_f}) - $signed((EXP_W + 2)'(BIAS));
endmodule

// File: rtl/fcvt_align_round.sv
module fcvt_align_round #(
  parameter int unsigned EXP_W = fcvt_pkg::FP_EXP_W,
  parameter int unsigned MAN_W = fcvt_pkg::FP_MAN_W,
  parameter int unsigned INT_W = fcvt_pkg::TGT_W
) (
  input  logic                     hidden,
  input  logic [MAN_W-1:0]         frac,
  input  logic signed [EXP_W+1:0]  uexp,
  input  logic                     neg,
  input  logic [2:0]               rm,
  output logic [INT_W:0]           mag,
  output logic                     inexact,
  output logic                     too_big
);
  localparam int unsigned SH_W = $clog2(INT_W);
  localparam int unsigned T_W  = INT_W + MAN_W + 1;

  logic [MAN_W:0]   sig;
  logic [T_W-1:0]   shifted;
  logic [INT_W:0]   ipart;
  logic             rbit;
  logic             sbit;
  logic             inc;
  logic             exp_neg;
  logic             exp_m1;

  assign sig     = {hidden, frac};
  assign exp_neg = uexp[EXP_W+1];
  assign exp_m1  = (uexp == {(EXP_W + 2){1'b1}});
  assign too_big = (uexp >= $signed((EXP_W + 2)'(INT_W)));

  always_comb begin
    shifted = {{INT_W{1'b0}}, sig} << uexp[SH_W-1:0];
    if (exp_neg) begin
      // Magnitude below one: the integer part is zero.
      ipart = '0;
      rbit  = exp_m1 & hidden;
      sbit  = exp_m1 ? (|frac) : (hidden | (|frac));
    end else begin
      ipart = shifted[T_W-1:MAN_W];
      rbit  = shifted[MAN_W-1];
      sbit  = |shifted[MAN_W-2:0];
    end
    inc     = fcvt_pkg::round_up(rm, neg, ipart[0], rbit, sbit);
    mag     = ipart + {{INT_W{1'b0}}, inc};
    inexact = rbit | sbit;
  end
endmodule

// File: rtl/fcvt_range_sat.sv
module fcvt_range_sat #(
  parameter int unsigned INT_W = fcvt_pkg::TGT_W,
  parameter int unsigned RES_W = 64
) (
  input  logic [INT_W:0]    mag,
  input  logic              too_big,
  input  logic              inexact,
  input  logic              neg,
  input  logic              is_signed,
  input  logic              is_nan,
  input  logic              is_inf,
  output logic [RES_W-1:0]  result,
  output logic              invalid,
  output logic              nx
);
  localparam logic [INT_W:0]   LIM_SPOS = {2'b00, {(INT_W - 1){1'b1}}};
  localparam logic [INT_W:0]   LIM_SNEG = {2'b01, {(INT_W - 1){1'b0}}};
  localparam logic [INT_W:0]   LIM_UPOS = {1'b0, {INT_W{1'b1}}};
  localparam logic [INT_W-1:0] MAX_S    = {1'b0, {(INT_W - 1){1'b1}}};
  localparam logic [INT_W-1:0] MIN_S    = {1'b1, {(INT_W - 1){1'b0}}};

  logic             range_bad;
  logic             sat_low;
  logic [INT_W-1:0] sat_val;
  logic [INT_W-1:0] in_val;
  logic [INT_W-1:0] word;

  always_comb begin
    if (is_signed) range_bad = neg ? (mag > LIM_SNEG) : (mag > LIM_SPOS);
    else           range_bad = neg ? (mag != '0)      : (mag > LIM_UPOS);
    invalid = is_nan | is_inf | too_big | range_bad;

    sat_low = neg & ~is_nan;
    if (sat_low) sat_val = is_signed ? MIN_S : '0;
    else         sat_val = is_signed ? MAX_S : '1;

    in_val = (neg & is_signed) ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
    word   = invalid ? sat_val : in_val;
    result = {{(RES_W - INT_W){word[INT_W-1]}}, word};
    nx     = inexact & ~invalid;
  end
endmodule

// File: rtl/fcvt_f64_i32.sv
module fcvt_f64_i32 #(
  parameter int unsigned EXP_W = fcvt_pkg::FP_EXP_W,
  parameter int unsigned MAN_W = fcvt_pkg::FP_MAN_W,
  parameter int unsigned INT_W = fcvt_pkg::TGT_W,
  parameter int unsigned RES_W = 64,
  localparam int unsigned OP_W = EXP_W + MAN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_operand,
  input  logic              in_signed,
  input  logic [2:0]        in_rm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RES_W-1:0]  out_result,
  output logic              out_nv,
  output logic              out_nx
);
  // Named internal events, observed by the bound checker.
  logic                    in_fire;
  logic                    w_sign;
  logic                    w_nan;
  logic                    w_inf;
  logic                    w_hidden;
  logic [MAN_W-1:0]        w_frac;
  logic signed [EXP_W+1:0] w_uexp;
  logic [INT_W:0]          w_mag;
  logic                    w_inexact;
  logic                    w_too_big;
  logic                    w_invalid;
  logic                    w_nx;
  logic [RES_W-1:0]        w_result;

  assign in_ready = ~out_valid | out_ready;
  assign in_fire  = in_valid & in_ready;

  fcvt_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
    .op     (in_operand),
    .sign   (w_sign),
    .is_nan (w_nan),
    .is_inf (w_inf),
    .hidden (w_hidden),
    .frac   (w_frac),
    .uexp   (w_uexp)
  );

  fcvt_align_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_round (
    .hidden  (w_hidden),
    .frac    (w_frac),
    .uexp    (w_uexp),
    .neg     (w_sign),
    .rm      (in_rm),
    .mag     (w_mag),
    .inexact (w_inexact),
    .too_big (w_too_big)
  );

  fcvt_range_sat #(.INT_W(INT_W), .RES_W(RES_W)) u_sat (
    .mag       (w_mag),
    .too_big   (w_too_big),
    .inexact   (w_inexact),
    .neg       (w_sign),
    .is_signed (in_signed),
    .is_nan    (w_nan),
    .is_inf    (w_inf),
    .result    (w_result),
    .invalid   (w_invalid),
    .nx        (w_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_nv     <= 1'b0;
      out_nx     <= 1'b0;
    end else if (in_fire) begin
      out_valid  <= 1'b1;
      out_result <= w_result;
      out_nv     <= w_invalid;
      out_nx     <= w_nx;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/fcvt_f64_i32_chk.sv
module fcvt_f64_i32_chk #(
  parameter int unsigned OP_W  = 64,
  parameter int unsigned INT_W = 32,
  parameter int unsigned RES_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OP_W-1:0]  in_operand,
  input logic             in_signed,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RES_W-1:0] out_result,
  input logic             out_nv,
  input logic             out_nx,
  input logic             w_nan
);
  localparam logic [RES_W-1:0] HI_S   = {{(RES_W - INT_W + 1){1'b0}}, {(INT_W - 1){1'b1}}};
  localparam logic [INT_W-1:0] MAX_S  = {1'b0, {(INT_W - 1){1'b1}}};
  localparam logic [INT_W-1:0] MIN_S  = {1'b1, {(INT_W - 1){1'b0}}};

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_nv) && $stable(out_nx)));

  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[RES_W-1:INT_W] == {(RES_W - INT_W){out_result[INT_W-1]}}));

  p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nv) |-> (out_result[INT_W-1:0] == MAX_S ||
                               out_result[INT_W-1:0] == MIN_S ||
                               out_result[INT_W-1:0] == '1 ||
                               out_result[INT_W-1:0] == '0));

  p_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && w_nan) |=>
      (out_valid && out_nv && out_result == ($past(in_signed) ? HI_S : '1)));

  p_uns_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_signed && in_operand[OP_W-1] && !w_nan) |=>
      (out_result == '0));

  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_nv && out_nx));
endmodule

bind fcvt_f64_i32 fcvt_f64_i32_chk #(.OP_W(OP_W), .INT_W(INT_W), .RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_operand (in_operand),
  .in_signed  (in_signed),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_nv     (out_nv),
  .out_nx     (out_nx),
  .w_nan      (w_nan)
);

// File: tb/fcvt_f64_i32_tb.sv
module fcvt_f64_i32_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic        in_signed = 1'b0;
  logic [2:0]  in_rm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_nv;
  logic        out_nx;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  fcvt_f64_i32 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_signed(in_signed), .in_rm(in_rm),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_nv(out_nv), .out_nx(out_nx)
  );

  localparam int NV = 40;
  // operand, signed, rm, expected result, nv, nx, requirement
  localparam logic [63:0] V_OP [NV] = '{
    64'h3FF8000000000000, 64'h4004000000000000, 64'h4004000000000000, 64'hC004000000000000, // R2
    64'hC004000000000000, 64'hC004000000000000, 64'h4004000000000000, 64'h3FF0000000000000, // R2, R10
    64'hC1E0000000000000, 64'h41E0000000000000, 64'h41DFFFFFFFE00000, 64'h41DFFFFFFFE00000, // R3
    64'hC1E0000000100000, 64'hC1E0000000100000, 64'hC1E0000000100000, 64'h41DFFFFFFFC00001, // R3, R4
    64'h41E65A0BC0000000, 64'h41EFFFFFFFF00000, 64'h41EFFFFFFFF00000, 64'h41E65A0BC0000000, // R4, R5, R6
    64'h4202A05F20000000, 64'hC202A05F20000000, 64'h4202A05F20000000, 64'hBFD3333333333333, // R6
    64'h7FF8000000000000, 64'h7FF8000000000000, 64'hFFF8000000000000, 64'h7FF0000000000000, // R7, R8
    64'hFFF0000000000000, 64'hFFF0000000000000, 64'h7FF0000000000000, 64'hBFD3333333333333, // R8, R9
    64'hBFD3333333333333, 64'hBFE0000000000000, 64'hBFE0000000000000, 64'h0000000000000000, // R9, R10
    64'h8000000000000000, 64'h0000000000000001, 64'h8000000000000001, 64'hBFE0000000000000  // R9, R10
  };
  localparam logic V_SG [NV] = '{
    1,1,1,1, 1,1,1,1, 1,1,1,1, 1,1,1,0, 0,0,0,1,
    1,1,0,0, 1,0,1,1, 1,0,0,0, 0,1,1,1, 0,1,1,0
  };
  localparam logic [2:0] V_RM [NV] = '{
    0,0,4,2, 1,3,5,0, 0,0,0,1, 1,0,2,3, 0,4,1,0,
    0,0,0,2, 0,0,0,0, 0,0,0,0, 1,0,4,0, 0,3,2,0
  };
  localparam logic [63:0] V_RES [NV] = '{
    64'h2, 64'h2, 64'h3, 64'hFFFFFFFFFFFFFFFD,
    64'hFFFFFFFFFFFFFFFE, 64'hFFFFFFFFFFFFFFFE, 64'h2, 64'h1,
    64'hFFFFFFFF80000000, 64'h7FFFFFFF, 64'h7FFFFFFF, 64'h7FFFFFFF,
    64'hFFFFFFFF80000000, 64'hFFFFFFFF80000000, 64'hFFFFFFFF80000000, 64'hFFFFFFFF80000000,
    64'hFFFFFFFFB2D05E00, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h7FFFFFFF,
    64'h7FFFFFFF, 64'hFFFFFFFF80000000, 64'hFFFFFFFFFFFFFFFF, 64'h0,
    64'h7FFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h7FFFFFFF, 64'h7FFFFFFF,
    64'hFFFFFFFF80000000, 64'h0, 64'hFFFFFFFFFFFFFFFF, 64'h0,
    64'h0, 64'h0, 64'hFFFFFFFFFFFFFFFF, 64'h0,
    64'h0, 64'h1, 64'hFFFFFFFFFFFFFFFF, 64'h0
  };
  localparam logic V_NV [NV] = '{
    0,0,0,0, 0,0,0,0, 0,1,1,0, 0,0,1,0, 0,1,0,1,
    1,1,1,1, 1,1,1,1, 1,1,1,0, 0,0,0,0, 0,0,0,0
  };
  localparam logic V_NX [NV] = '{
    1,1,1,1, 1,1,1,0, 0,0,0,1, 1,1,0,1, 0,0,1,0,
    0,0,0,0, 0,0,0,0, 0,0,0,1, 1,1,1,0, 0,1,1,1
  };
  localparam int V_REQ [NV] = '{
    2,2,2,2, 2,2,2,10, 3,3,3,3, 3,3,6,4, 4,5,5,6,
    6,6,6,6, 7,7,7,8, 8,8,8,9, 9,10,10,10, 9,10,10,9
  };

  task automatic check(input bit ok, input int req, input logic [65:0] got,
                       input logic [65:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d: got result=%h nv=%b nx=%b, expected result=%h nv=%b nx=%b",
               req, got[65:2], got[1], got[0], exp[65:2], exp[1], exp[0]);
    end
  endtask

  task automatic run_vec(input logic [63:0] op, input logic sg, input logic [2:0] rm,
                         input logic [63:0] er, input logic env, input logic enx,
                         input int req);
    @(negedge clk);
    in_operand = op; in_signed = sg; in_rm = rm; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_result === er && out_nv === env && out_nx === enx,
          req, {out_result, out_nv, out_nx}, {er, env, enx});
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R11: state while reset is held and just after release
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, 11, {64'h0, out_valid, in_ready},
          {64'h0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, 11, {64'h0, out_valid, in_ready},
          {64'h0, 1'b0, 1'b1});

    for (int i = 0; i < NV; i++)
      run_vec(V_OP[i], V_SG[i], V_RM[i], V_RES[i], V_NV[i], V_NX[i], V_REQ[i]);

    // R1: back-pressure holds the first result and stalls the second operand
    @(negedge clk);
    out_ready = 1'b0;
    in_operand = 64'h4004000000000000; in_signed = 1'b1; in_rm = 3'd4; in_valid = 1'b1;
    @(negedge clk);
    in_operand = 64'hC004000000000000; in_rm = 3'd1;  // second operand waits
    for (int k = 0; k < 3; k++) begin
      check(out_valid === 1'b1 && in_ready === 1'b0 && out_result === 64'h3,
            1, {out_result, out_valid, in_ready}, {64'h3, 1'b1, 1'b0});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_result === 64'hFFFFFFFFFFFFFFFE && out_nx === 1'b1,
          1, {out_result, out_valid, out_nx}, {64'hFFFFFFFFFFFFFFFE, 1'b1, 1'b1});
    @(negedge clk);
    check(out_valid === 1'b0, 1, {64'h0, out_valid, 1'b0}, {64'h0, 1'b0, 1'b0});

    finish_run();
  end
endmodule